// File: doc/BRIEF.md
# Software Breakpoint Trap Unit

This unit sits beside a CPU core and watches the stream of executed opcodes for the breakpoint code A5h. When the debug arm bit is set and that opcode executes, the unit enters breakpoint mode. It freezes the clocks of every timer and of the watchdog. It halts each serial channel whose bit clock comes from a timer. It suspends the sequencer that unlocks protected registers. It sends the core to the fixed debug vector 000083h.

The address the core would have fetched next is not pushed to a stack. The unit keeps it in three byte-wide registers, which a debug monitor can read and rewrite while breakpoint mode lasts. When A5h executes again during breakpoint mode, the unit leaves the mode, releases every freeze, and loads the program counter with the three stored bytes.

Top module: `brk_trap_unit`

## Requirements
- R1: After reset, `brk_active`, `pc_load`, `pc_target`, every freeze output and `ta_suspend` are 0, and all three saved address bytes read 00h.
- R2: The trap condition is `exec_stb`=1, `exec_op`=A5h, `dbg_arm`=1 and `brk_active`=0 in the same cycle. In the next cycle `brk_active` is 1, `pc_load` is 1 for that one cycle with `pc_target`=000083h, and the stored address equals the `next_pc` sampled with the strobe.
- R3: Readback uses `reg_sel`. Code 0 reads bits 7:0 of the stored address, code 1 reads bits 15:8, code 2 reads bits 23:16, and code 3 always reads 00h.
- R4: While `brk_active` is 1, all bits of `tmr_freeze`, `wdt_freeze` and `ta_suspend` are 1, and `ser_halt` equals `ser_uses_tmr`. While `brk_active` is 0, all of these outputs are 0. They change on the same edge as the matching `pc_load` pulse.
- R5: With `dbg_arm`=0 and breakpoint mode inactive, an A5h strobe has no effect. No `pc_load` occurs, breakpoint mode stays off, and the stored bytes are unchanged.
- R6: A strobe carrying any opcode other than A5h, or A5h presented with `exec_stb`=0, has no effect on mode, `pc_load` or the stored bytes.
- R7: An A5h strobe while `brk_active`=1 always means return, whatever `dbg_arm` is. In the next cycle `brk_active` is 0 and `pc_load` is 1 with `pc_target` equal to the stored address.
- R8: `reg_we`=1 with `reg_sel` 0, 1 or 2 while `brk_active`=1 replaces that byte with `reg_wdata` on the next edge. The write is ignored while inactive, and it is ignored for `reg_sel`=3.
- R9: When a byte write and a return strobe fall in the same cycle, `pc_target` uses the bytes as they were before that write, and the write still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_arm | input | 1 | Breakpoint arm bit from the CPU control register |
| exec_stb | input | 1 | One-cycle strobe: an opcode executes |
| exec_op | input | 8 | Opcode byte qualified by `exec_stb` |
| next_pc | input | 24 | Address the core would fetch next |
| ser_uses_tmr | input | 2 | Per serial channel: 1 when its bit clock comes from a timer |
| pc_load | output | 1 | One-cycle request to load `pc_target` into the PC |
| pc_target | output | 24 | PC value to load |
| tmr_freeze | output | 4 | Clock stop for each timer |
| wdt_freeze | output | 1 | Clock stop for the watchdog |
| ser_halt | output | 2 | Halt for each timer-clocked serial channel |
| ta_suspend | output | 1 | Suspend for the protected-register unlock sequencer |
| brk_active | output | 1 | Breakpoint mode active |
| reg_we | input | 1 | Write strobe for a stored address byte |
| reg_sel | input | 2 | Byte select (0 low, 1 middle, 2 extended, 3 none) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |

## Verification
The hardest situation to reach from the ports is a return strobe that lands in the same cycle as a byte write. In that cycle the target must come from the old contents while the new byte is still stored. A related hard case is a return issued with `dbg_arm` already cleared. The random phase keeps the opcode at A5h for a large share of strobes and toggles the arm bit, writes and selects on their own. The bench model follows every one of these orderings cycle by cycle. Directed steps first force a trap, an edit of the resume address, and a return taken while disarmed.

// File: rtl/brk_pkg.sv
package brk_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] BRK_OPCODE = 8'hA5;

   typedef struct packed {
      logic trap;
      logic ret;
   } brk_evt_t;
endpackage

// File: rtl/brk_decode.sv
module brk_decode
   import brk_pkg::*;
#(
   parameter logic [BYTE_W-1:0] OPCODE = BRK_OPCODE
) (
   input  logic              exec_stb,
   input  logic [BYTE_W-1:0] exec_op,
   input  logic              dbg_arm,
   input  logic              active,
   output brk_evt_t          evt
);
   logic hit;

   always_comb begin
      hit       = exec_stb && (exec_op == OPCODE);
      evt.trap  = hit && dbg_arm && !active;
      evt.ret   = hit && active;
   end
endmodule

// File: rtl/brk_addr_bank.sv
module brk_addr_bank
   import brk_pkg::*;
#(
   parameter int unsigned NBYTES = 3,
   parameter int unsigned SEL_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     capture,
   input  logic [NBYTES*BYTE_W-1:0] capture_val,
   input  logic                     wr_open,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         sel,
   input  logic [BYTE_W-1:0]        wdata,
   output logic [NBYTES*BYTE_W-1:0] saved,
   output logic [BYTE_W-1:0]        rdata
);
   logic [NBYTES-1:0][BYTE_W-1:0] bytes_q;
   logic [NBYTES-1:0]             hit;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign hit[g] = (sel == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bytes_q[g] <= '0;
         end else if (capture) begin
            bytes_q[g] <= capture_val[g*BYTE_W +: BYTE_W];
         end else if (wr_open && wr_en && hit[g]) begin
            bytes_q[g] <= wdata;
         end
      end

      assign saved[g*BYTE_W +: BYTE_W] = bytes_q[g];
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < int'(NBYTES); i++) begin
         if (hit[i]) rdata = bytes_q[i];
      end
   end
endmodule

// File: rtl/brk_freeze.sv
module brk_freeze #(
   parameter int unsigned NUM_TMR = 4,
   parameter int unsigned NUM_SER = 2
) (
   input  logic               active,
   input  logic [NUM_SER-1:0] ser_uses_tmr,
   output logic [NUM_TMR-1:0] tmr_freeze,
   output logic               wdt_freeze,
   output logic [NUM_SER-1:0] ser_halt,
   output logic               ta_suspend
);
   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      assign tmr_freeze[t] = active;
   end

   for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
      assign ser_halt[s] = active & ser_uses_tmr[s];
   end

   assign wdt_freeze = active;
   assign ta_suspend = active;
endmodule

// File: rtl/brk_trap_unit.sv
module brk_trap_unit
   import brk_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned NUM_TMR    = 4,
   parameter int unsigned NUM_SER    = 2,
   parameter int unsigned VECTOR     = 32'h0000_0083,
   parameter logic [7:0]  OPCODE     = BRK_OPCODE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dbg_arm,
   input  logic                         exec_stb,
   input  logic [7:0]                   exec_op,
   input  logic [ADDR_BYTES*8-1:0]      next_pc,
   input  logic [NUM_SER-1:0]           ser_uses_tmr,
   output logic                         pc_load,
   output logic [ADDR_BYTES*8-1:0]      pc_target,
   output logic [NUM_TMR-1:0]           tmr_freeze,
   output logic                         wdt_freeze,
   output logic [NUM_SER-1:0]           ser_halt,
   output logic                         ta_suspend,
   output logic                         brk_active,
   input  logic                         reg_we,
   input  logic [$clog2(ADDR_BYTES+1)-1:0] reg_sel,
   input  logic [7:0]                   reg_wdata,
   output logic [7:0]                   reg_rdata
);
   localparam int unsigned ADDR_W = ADDR_BYTES * BYTE_W;
   localparam int unsigned SEL_W  = $clog2(ADDR_BYTES + 1);

   if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_bytes
      $error("ADDR_BYTES must lie in 1..4");
   end
   if (NUM_TMR < 1 || NUM_SER < 1) begin : g_bad_counts
      $error("NUM_TMR and NUM_SER must be at least 1");
   end
   if (ADDR_BYTES < 4 && VECTOR >= (32'd1 << ADDR_W)) begin : g_bad_vec
      $error("VECTOR does not fit the address width");
   end

   brk_evt_t          evt;
   logic              active_q;
   logic              load_q;
   logic [ADDR_W-1:0] target_q;
   logic [ADDR_W-1:0] saved_addr;

   brk_decode #(.OPCODE(OPCODE)) u_dec (
      .exec_stb (exec_stb),
      .exec_op  (exec_op),
      .dbg_arm  (dbg_arm),
      .active   (active_q),
      .evt      (evt)
   );

   brk_addr_bank #(.NBYTES(ADDR_BYTES), .SEL_W(SEL_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (evt.trap),
      .capture_val (next_pc),
      .wr_open     (active_q),
      .wr_en       (reg_we),
      .sel         (reg_sel),
      .wdata       (reg_wdata),
      .saved       (saved_addr),
      .rdata       (reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         load_q   <= 1'b0;
         target_q <= '0;
      end else begin
         load_q <= evt.trap | evt.ret;
         if (evt.trap) begin
            active_q <= 1'b1;
            target_q <= ADDR_W'(VECTOR);
         end else if (evt.ret) begin
            active_q <= 1'b0;
            target_q <= saved_addr;
         end
      end
   end

   brk_freeze #(.NUM_TMR(NUM_TMR), .NUM_SER(NUM_SER)) u_frz (
      .active       (active_q),
      .ser_uses_tmr (ser_uses_tmr),
      .tmr_freeze   (tmr_freeze),
      .wdt_freeze   (wdt_freeze),
      .ser_halt     (ser_halt),
      .ta_suspend   (ta_suspend)
   );

   assign pc_load    = load_q;
   assign pc_target  = target_q;
   assign brk_active = active_q;
endmodule

// File: rtl/brk_trap_chk.sv
module brk_trap_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned VECTOR = 32'h83,
   parameter logic [7:0]  OPCODE = 8'hA5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dbg_arm,
   input logic              exec_stb,
   input logic [7:0]        exec_op,
   input logic              reg_we,
   input logic [SEL_W-1:0]  reg_sel,
   input logic              brk_active,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_target,
   input logic [ADDR_W-1:0] saved_addr,
   input logic              ta_suspend
);
   // R2
   entry_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && exec_op == OPCODE && dbg_arm && !brk_active)
      |=> (brk_active && pc_load && pc_target == ADDR_W'(VECTOR)));

   // R7
   exit_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && exec_op == OPCODE && brk_active)
      |=> (!brk_active && pc_load && pc_target == $past(saved_addr)));

   // R5
   disarmed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && exec_op == OPCODE && !dbg_arm && !brk_active)
      |=> (!brk_active && !pc_load && $stable(saved_addr)));

   // R6
   load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pc_load) |-> $past(exec_stb && exec_op == OPCODE));

   // R8
   idle_regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_active && !(exec_stb && exec_op == OPCODE && dbg_arm))
      |=> $stable(saved_addr));

   // R4
   suspend_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ta_suspend) || $fell(ta_suspend)) |-> pc_load);

   // R8
   sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == SEL_W'(3) && !(exec_stb && exec_op == OPCODE))
      |=> $stable(saved_addr));
endmodule

bind brk_trap_unit brk_trap_chk #(
   .ADDR_W (ADDR_BYTES*8),
   .SEL_W  ($clog2(ADDR_BYTES+1)),
   .VECTOR (VECTOR),
   .OPCODE (OPCODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_arm    (dbg_arm),
   .exec_stb   (exec_stb),
   .exec_op    (exec_op),
   .reg_we     (reg_we),
   .reg_sel    (reg_sel),
   .brk_active (brk_active),
   .pc_load    (pc_load),
   .pc_target  (pc_target),
   .saved_addr (saved_addr),
   .ta_suspend (ta_suspend)
);

// File: tb/brk_trap_unit_tb.sv
module brk_trap_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_arm = 1'b0;
   logic        exec_stb = 1'b0;
   logic [7:0]  exec_op = 8'h00;
   logic [23:0] next_pc = 24'h0;
   logic [1:0]  ser_uses_tmr = 2'b00;
   logic        pc_load;
   logic [23:0] pc_target;
   logic [3:0]  tmr_freeze;
   logic        wdt_freeze;
   logic [1:0]  ser_halt;
   logic        ta_suspend;
   logic        brk_active;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;

   int n_chk = 0;
   int n_fail = 0;

   // model state
   logic        m_act;
   logic        m_load;
   logic [23:0] m_tgt;
   logic [7:0]  m_b [3];

   brk_trap_unit u_dut (
      .clk(clk), .rst_n(rst_n), .dbg_arm(dbg_arm), .exec_stb(exec_stb),
      .exec_op(exec_op), .next_pc(next_pc), .ser_uses_tmr(ser_uses_tmr),
      .pc_load(pc_load), .pc_target(pc_target), .tmr_freeze(tmr_freeze),
      .wdt_freeze(wdt_freeze), .ser_halt(ser_halt), .ta_suspend(ta_suspend),
      .brk_active(brk_active), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   always #5 clk = ~clk;

   function automatic logic [23:0] m_addr();
      return {m_b[2], m_b[1], m_b[0]};
   endfunction

   function automatic logic [7:0] m_read(input logic [1:0] s);
      return (s == 2'd3) ? 8'h00 : m_b[s];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // advance model on a clock edge using the inputs held across it
   task automatic model_edge();
      logic hit, trap, ret;
      logic [23:0] old;
      hit  = exec_stb && exec_op == 8'hA5;
      trap = hit && dbg_arm && !m_act;
      ret  = hit && m_act;
      old  = m_addr();
      m_load = trap || ret;
      if (trap) begin
         m_tgt = 24'h000083;
         m_b[0] = next_pc[7:0]; m_b[1] = next_pc[15:8]; m_b[2] = next_pc[23:16];
      end else begin
         if (ret) m_tgt = old;   // R9: target from pre-write bytes
         if (m_act && reg_we && reg_sel != 2'd3) m_b[reg_sel] = reg_wdata;
      end
      if (trap) m_act = 1'b1;
      else if (ret) m_act = 1'b0;
   endtask

   task automatic compare_all(input string tag);
      chk("R2/R7", {tag, " brk_active"}, 32'(brk_active), 32'(m_act));
      chk("R2/R7", {tag, " pc_load"}, 32'(pc_load), 32'(m_load));
      if (m_load) chk("R2/R7/R9", {tag, " pc_target"}, 32'(pc_target), 32'(m_tgt));
      chk("R4", {tag, " tmr_freeze"}, 32'(tmr_freeze), 32'({4{m_act}}));
      chk("R4", {tag, " wdt_freeze"}, 32'(wdt_freeze), 32'(m_act));
      chk("R4", {tag, " ta_suspend"}, 32'(ta_suspend), 32'(m_act));
      chk("R4", {tag, " ser_halt"}, 32'(ser_halt), 32'(ser_uses_tmr & {2{m_act}}));
      chk("R3/R8", {tag, " reg_rdata"}, 32'(reg_rdata), 32'(m_read(reg_sel)));
   endtask

   task automatic cyc(input logic arm, input logic stb, input logic [7:0] op,
                      input logic [23:0] npc, input logic we, input logic [1:0] sel,
                      input logic [7:0] wd, input string tag);
      @(negedge clk);
      dbg_arm = arm; exec_stb = stb; exec_op = op; next_pc = npc;
      reg_we = we; reg_sel = sel; reg_wdata = wd;
      @(posedge clk);
      model_edge();
      #2;
      compare_all(tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_0B17));
      m_act = 0; m_load = 0; m_tgt = 0;
      m_b[0] = 0; m_b[1] = 0; m_b[2] = 0;
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1", "brk_active", 32'(brk_active), 0);
      chk("R1", "pc_load", 32'(pc_load), 0);
      chk("R1", "pc_target", 32'(pc_target), 0);
      chk("R1", "freezes", 32'({tmr_freeze, wdt_freeze, ser_halt, ta_suspend}), 0);
      chk("R1", "byte0", 32'(reg_rdata), 0);
      @(negedge clk); rst_n = 1'b1;
      ser_uses_tmr = 2'b10;

      // R5 disarmed A5 ignored
      cyc(0, 1, 8'hA5, 24'h123456, 0, 0, 0, "R5 disarmed");
      cyc(0, 0, 8'h00, 24'h0, 0, 2, 0, "R5 after");
      // R6 other opcode and no strobe
      cyc(1, 1, 8'hA4, 24'h111111, 0, 0, 0, "R6 other op");
      cyc(1, 0, 8'hA5, 24'h222222, 0, 0, 0, "R6 no strobe");
      // R2 trap
      cyc(1, 1, 8'hA5, 24'hABCDEF, 0, 0, 0, "R2 trap");
      cyc(1, 0, 8'h00, 24'h0, 0, 1, 0, "R3 read mid");
      cyc(1, 0, 8'h00, 24'h0, 0, 2, 0, "R3 read ext");
      cyc(1, 0, 8'h00, 24'h0, 0, 3, 0, "R3 read none");
      // R8 edit resume address, sel 3 ignored
      cyc(1, 0, 8'h00, 24'h0, 1, 0, 8'h5A, "R8 write lo");
      cyc(1, 0, 8'h00, 24'h0, 1, 3, 8'hFF, "R8 write none");
      // R7 + R9: return while disarmed, with a write in the same cycle
      cyc(0, 1, 8'hA5, 24'h0, 1, 2, 8'h77, "R7 R9 return");
      cyc(0, 0, 8'h00, 24'h0, 0, 2, 0, "R9 write landed");
      // R8 write ignored while inactive
      cyc(0, 0, 8'h00, 24'h0, 1, 1, 8'h99, "R8 idle write");
      cyc(0, 0, 8'h00, 24'h0, 0, 1, 0, "R8 idle readback");

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] op;
         op = ($urandom_range(0, 9) < 5) ? 8'hA5 : 8'($urandom);
         if (i % 200 == 0) ser_uses_tmr = 2'($urandom);
         cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) == 0), op,
             24'($urandom), ($urandom_range(0, 2) == 0), 2'($urandom),
             8'($urandom), "rand");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule